// File: doc/BRIEF.md
# MDIO Management Target

This block is the serial management endpoint of a physical-layer device. It is clocked by the management clock driven by a bus master. It watches the bidirectional data line, recognises Clause-22-style read and write frames addressed to it, and turns each one into a single access on a simple internal register bus. The bus reaches a bank of up to thirty-two 16-bit registers. Registers 0 to 8 form the standard set. Higher addresses hold extended functions.

The device answers at one of two bus addresses, 0 or 3, picked by a 2-bit strap. The upper three address bits must be zero. A read raises a one-cycle strobe at the moment the register value is taken, so clear-on-read status registers behave correctly. Register addresses outside a parameterised implemented set read back as zero and cannot be written.

Top module: `mdio_mgmt_target`

## Requirements
- R1: While reset is asserted and after it is released, `mdio_oe`, `reg_rd` and `reg_wr` are all low until a valid frame arrives.
- R2: The block decodes a frame only after at least 32 consecutive ones, sampled on rising clock edges, followed by the start bits 0 then 1. With 31 or fewer ones, the frame is ignored.
- R3: The 5-bit device address (MSB first) must equal 0 when `phy_strap` is 2'b00, and 3 for any other strap value. A frame with any other device address leaves `mdio_oe` low and raises no strobe.
- R4: On a read (opcode bits 1 then 0), the first turnaround bit is left undriven. The block then drives 0 for the second turnaround bit, then 16 data bits MSB first, each bit changing just after a rising edge. It releases the line after the last bit.
- R5: For a read of an implemented register, `reg_rd` is high for exactly one clock, during the second turnaround bit, with `reg_addr` equal to the 5-bit register address. The value on `reg_rdata` in that cycle is the value sent.
- R6: On a write (opcode bits 0 then 1) with turnaround bits 1 then 0, the 16 data bits (MSB first) are presented on `reg_wdata`. `reg_wr` pulses for exactly one clock, in the cycle after the edge that samples the last data bit.
- R7: A write whose turnaround bits are not 1 then 0 is discarded, and no `reg_wr` pulse occurs.
- R8: A register address whose bit in `IMPL_MASK` is clear (default mask 32'h8800_01FF: registers 0 to 8, 27 and 31) reads back as all zeros with full read timing and no `reg_rd`. A write to it raises no `reg_wr`.
- R9: After any frame ends or is rejected, a new preamble of at least 32 ones is needed before the next frame. Start bits sent straight after a frame are ignored.
- R10: Opcodes 00 and 11 are not reads or writes. Such a frame is ignored, with no drive and no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock from the bus master |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdio_i | input | 1 | Data line as seen at the pad |
| mdio_o | output | 1 | Value driven onto the data line |
| mdio_oe | output | 1 | High while the block drives the data line |
| phy_strap | input | 2 | Address strap: 00 selects address 0, any other value selects address 3 |
| reg_addr | output | 5 | Register address of the current access |
| reg_wdata | output | 16 | Write data, valid while `reg_wr` is high |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rdata | input | 16 | Read data from the register bank |
| reg_rd | output | 1 | One-cycle read strobe when the read value is taken |

## Verification
A wrong frame state shows up at the line within one bit time. A misplaced turnaround moves the rising edge of `mdio_oe`, or the leading 0, by a whole clock. A wrong bit count shifts the returned word, or leaves the line driven into the idle period. A preamble counter that does not clear, or an address compare that is too loose, shows up as a drive or strobe on a frame that should be silent. A wrong implemented-register decode shows up as non-zero read data, or as a stray `reg_rd` or `reg_wr` on an unimplemented address, within the same frame.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int PHY_AW = 5;
  localparam int REG_AW = 5;
  localparam int NUM_REGS = 1 << REG_AW;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START,
    ST_HDR,
    ST_RTA1,
    ST_RTA2,
    ST_RDATA,
    ST_WTA1,
    ST_WTA2,
    ST_WDATA
  } mstate_t;

  // strap 00 selects device address 0, anything else selects address 3
  function automatic logic [PHY_AW-1:0] strap_to_phy(input logic [1:0] strap);
    return (strap == 2'b00) ? PHY_AW'(0) : PHY_AW'(3);
  endfunction

  function automatic logic reg_present(input logic [NUM_REGS-1:0] mask,
                                       input logic [REG_AW-1:0] ra);
    return mask[ra];
  endfunction

endpackage

// File: rtl/mdio_preamble_det.sv
module mdio_preamble_det #(
  parameter int PRE_LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hunt,
  input  logic bit_in,
  output logic pre_ok
);
  localparam int CW = $clog2(PRE_LEN + 1);

  logic [CW-1:0] ones_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ones_q <= '0;
    else if (!hunt || !bit_in)
      ones_q <= '0;
    else if (ones_q != CW'(PRE_LEN))
      ones_q <= ones_q + 1'b1;
  end

  assign pre_ok = (ones_q == CW'(PRE_LEN));

  // R2: once enough ones are seen, further ones keep the count saturated
  assert_preamble_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hunt && bit_in && pre_ok) |=> pre_ok);

  // R9: leaving the hunt state discards the ones already counted
  assert_preamble_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !hunt |=> !pre_ok);

endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl import mdio_mgmt_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_in,
  input  logic              pre_ok,
  input  logic [1:0]        phy_strap,
  output mstate_t           state,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              hunt,
  output logic [REG_AW-1:0] reg_addr
);
  localparam int HDR_BITS = 2 + PHY_AW + REG_AW;

  mstate_t              state_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [HDR_BITS-2:0]  hdr_q;
  logic [REG_AW-1:0]    ra_q;

  // named internal events
  logic [HDR_BITS-1:0]  hdr_nx;
  logic                 hdr_last;
  logic                 phy_match;
  logic                 rd_hit;
  logic                 wr_hit;
  logic                 data_last;

  assign hdr_nx    = {hdr_q, bit_in};
  assign hdr_last  = (state_q == ST_HDR) && (cnt_q == CNT_W'(HDR_BITS - 1));
  assign phy_match = (hdr_nx[REG_AW +: PHY_AW] == strap_to_phy(phy_strap));
  assign rd_hit    = hdr_last && phy_match && (hdr_nx[HDR_BITS-1 -: 2] == OPC_READ);
  assign wr_hit    = hdr_last && phy_match && (hdr_nx[HDR_BITS-1 -: 2] == OPC_WRITE);
  assign data_last = (cnt_q == CNT_W'(DATA_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      hdr_q   <= '0;
      ra_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE:  if (pre_ok && !bit_in) state_q <= ST_START;
        ST_START: begin
          cnt_q   <= '0;
          state_q <= bit_in ? ST_HDR : ST_IDLE;
        end
        ST_HDR: begin
          hdr_q <= hdr_nx[HDR_BITS-2:0];
          if (hdr_last) begin
            cnt_q <= '0;
            ra_q  <= hdr_nx[REG_AW-1:0];
            if (rd_hit)      state_q <= ST_RTA1;
            else if (wr_hit) state_q <= ST_WTA1;
            else             state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_RTA1: state_q <= ST_RTA2;
        ST_RTA2: begin
          cnt_q   <= '0;
          state_q <= ST_RDATA;
        end
        ST_RDATA: begin
          if (data_last) state_q <= ST_IDLE;
          else           cnt_q   <= cnt_q + 1'b1;
        end
        ST_WTA1: state_q <= bit_in ? ST_WTA2 : ST_IDLE;
        ST_WTA2: begin
          cnt_q   <= '0;
          state_q <= bit_in ? ST_IDLE : ST_WDATA;
        end
        ST_WDATA: begin
          if (data_last) state_q <= ST_IDLE;
          else           cnt_q   <= cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state    = state_q;
  assign bit_cnt  = cnt_q;
  assign hunt     = (state_q == ST_IDLE);
  assign reg_addr = ra_q;

  // R2: a start pattern is only taken after a full preamble
  assert_start_needs_pre_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START) |-> $past(pre_ok));

  // R3: a header that addresses another device returns to hunting
  assert_foreign_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_last && !phy_match) |=> (state_q == ST_IDLE));

  // R7: a write turnaround that does not start with 1 aborts the frame
  assert_write_ta_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_WTA1) && !bit_in) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/mdio_xfer_path.sv
module mdio_xfer_path import mdio_mgmt_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_in,
  input  mstate_t           state,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic              reg_ok,
  input  logic [DATA_W-1:0] rd_word,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] wr_word,
  output logic              wr_pulse
);
  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-1:0] rx_q;
  logic              out_q;
  logic              oe_q;
  logic              wr_q;

  logic              last_bit;
  logic [DATA_W-1:0] rd_src;
  logic [DATA_W-1:0] rx_nx;

  assign last_bit = (bit_cnt == CNT_W'(DATA_W - 1));
  assign rd_src   = reg_ok ? rd_word : '0;
  assign rx_nx    = {rx_q[DATA_W-2:0], bit_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      out_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      case (state)
        ST_RTA1: begin
          oe_q  <= 1'b1;
          out_q <= 1'b0;
        end
        ST_RTA2: begin
          out_q <= rd_src[DATA_W-1];
          tx_q  <= {rd_src[DATA_W-2:0], 1'b0};
        end
        ST_RDATA: begin
          if (last_bit) begin
            oe_q  <= 1'b0;
            out_q <= 1'b0;
          end else begin
            out_q <= tx_q[DATA_W-1];
            tx_q  <= {tx_q[DATA_W-2:0], 1'b0};
          end
        end
        default: begin
          oe_q  <= 1'b0;
          out_q <= 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '0;
      wr_q <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      if (state == ST_WDATA) begin
        rx_q <= rx_nx;
        if (last_bit) wr_q <= reg_ok;
      end
    end
  end

  assign mdio_o   = out_q;
  assign mdio_oe  = oe_q;
  assign wr_word  = rx_q;
  assign wr_pulse = wr_q;

  // R4: the line is released at the end of the data field
  assert_release_after_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_RDATA) && last_bit) |=> !mdio_oe);

  // R6: a write strobe is a single-cycle pulse
  assert_wr_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);

endmodule

// File: rtl/mdio_mgmt_target.sv
module mdio_mgmt_target import mdio_mgmt_pkg::*; #(
  parameter int                  DATA_W    = 16,
  parameter int                  PRE_LEN   = 32,
  parameter logic [NUM_REGS-1:0] IMPL_MASK = 32'h8800_01FF
) (
  input  logic              mdc,
  input  logic              rst_n,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic [1:0]        phy_strap,
  output logic [REG_AW-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rd
);
  localparam int HDR_BITS = 2 + PHY_AW + REG_AW;
  localparam int CNT_MAX  = (DATA_W > HDR_BITS) ? DATA_W : HDR_BITS;
  localparam int CNT_W    = $clog2(CNT_MAX);

  mstate_t          state;
  logic [CNT_W-1:0] bit_cnt;
  logic             hunt;
  logic             pre_ok;
  logic             reg_ok;

  mdio_preamble_det #(.PRE_LEN(PRE_LEN)) pre_i (
    .clk    (mdc),
    .rst_n  (rst_n),
    .hunt   (hunt),
    .bit_in (mdio_i),
    .pre_ok (pre_ok)
  );

  mdio_frame_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) ctrl_i (
    .clk       (mdc),
    .rst_n     (rst_n),
    .bit_in    (mdio_i),
    .pre_ok    (pre_ok),
    .phy_strap (phy_strap),
    .state     (state),
    .bit_cnt   (bit_cnt),
    .hunt      (hunt),
    .reg_addr  (reg_addr)
  );

  assign reg_ok = reg_present(IMPL_MASK, reg_addr);
  assign reg_rd = (state == ST_RTA2) && reg_ok;

  mdio_xfer_path #(.DATA_W(DATA_W), .CNT_W(CNT_W)) path_i (
    .clk      (mdc),
    .rst_n    (rst_n),
    .bit_in   (mdio_i),
    .state    (state),
    .bit_cnt  (bit_cnt),
    .reg_ok   (reg_ok),
    .rd_word  (reg_rdata),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .wr_word  (reg_wdata),
    .wr_pulse (reg_wr)
  );

  // R5: the read strobe lasts one cycle and is followed by a driven data bit
  assert_rd_strobe_R5: assert property (@(posedge mdc) disable iff (!rst_n)
    reg_rd |=> (mdio_oe && !reg_rd));

  // R4: the first driven turnaround bit is zero
  assert_ta_zero_R4: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);

  // R6: the block never writes while it is driving the line
  assert_wr_not_driving_R6: assert property (@(posedge mdc) disable iff (!rst_n)
    reg_wr |-> !mdio_oe);

  // R8: strobes only ever reach implemented registers
  assert_wr_implemented_R8: assert property (@(posedge mdc) disable iff (!rst_n)
    reg_wr |-> IMPL_MASK[reg_addr]);

  // R1: nothing is driven or strobed in the cycle after reset release
  assert_quiet_after_reset_R1: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(rst_n) |-> (!mdio_oe && !reg_wr && !reg_rd));

endmodule

// File: tb/mdio_mgmt_target_tb.sv
module mdio_mgmt_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] IMPL_B = 32'h8800_01FF;

  logic        mdc = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_drv = 1'b1;
  logic        mdio_line;
  logic        mdio_o, mdio_oe;
  logic [1:0]  phy_strap = 2'b00;
  logic [4:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        reg_wr, reg_rd;

  logic [15:0] model [32];
  int n_chk = 0;
  int n_fail = 0;
  int rd_pulses = 0;
  int wr_pulses = 0;

  always #(CLK_PERIOD/2) mdc = ~mdc;

  assign mdio_line = mdio_oe ? mdio_o : m_drv;
  assign reg_rdata = model[reg_addr];

  mdio_mgmt_target dut_i (
    .mdc(mdc), .rst_n(rst_n), .mdio_i(mdio_line), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .phy_strap(phy_strap), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rdata(reg_rdata),
    .reg_rd(reg_rd)
  );

  always @(negedge mdc) begin
    if (reg_rd) rd_pulses++;
    if (reg_wr) begin
      wr_pulses++;
      model[reg_addr] <= reg_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge mdc);
    m_drv = b;
  endtask

  task automatic start_frame(input int npre, input logic [1:0] op,
                             input logic [4:0] phy, input logic [4:0] ra);
    if (npre > 0) begin
      send_bit(1'b0);
      send_bit(1'b0);
    end
    for (int i = 0; i < npre; i++) send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    for (int i = 1; i >= 0; i--) send_bit(op[i]);
    for (int i = 4; i >= 0; i--) send_bit(phy[i]);
    for (int i = 4; i >= 0; i--) send_bit(ra[i]);
  endtask

  task automatic read_frame(input int npre, input logic [4:0] phy, input logic [4:0] ra,
                            input bit exp_drive, input bit exp_strobe,
                            input logic [15:0] exp_data, input string req);
    logic [15:0] got;
    int rd0;
    bit oe_bad;
    got = '0;
    oe_bad = 1'b0;
    start_frame(npre, 2'b10, phy, ra);
    rd0 = rd_pulses;
    @(negedge mdc);
    m_drv = 1'b1;
    chk(!mdio_oe, req, "first turnaround bit undriven", mdio_oe, 0);
    @(negedge mdc);
    if (exp_drive) begin
      chk(mdio_oe && !mdio_o, req, "second turnaround bit driven 0", {mdio_oe, mdio_o}, 2'b10);
      chk(reg_rd == exp_strobe, req, "read strobe in turnaround", reg_rd, exp_strobe);
      if (exp_strobe) chk(reg_addr == ra, req, "read strobe address", reg_addr, ra);
    end else begin
      chk(!mdio_oe && !reg_rd, req, "no drive or strobe", {mdio_oe, reg_rd}, 0);
    end
    for (int i = 15; i >= 0; i--) begin
      @(negedge mdc);
      got[i] = mdio_o;
      if (mdio_oe != exp_drive) oe_bad = 1'b1;
    end
    chk(!oe_bad, req, "drive enable during data field", oe_bad, 0);
    if (exp_drive) chk(got == exp_data, req, "read data", got, exp_data);
    @(negedge mdc);
    chk(!mdio_oe, req, "line released after data", mdio_oe, 0);
    chk(rd_pulses - rd0 == int'(exp_strobe), req, "read strobe count",
        rd_pulses - rd0, int'(exp_strobe));
  endtask

  task automatic write_frame(input int npre, input logic [1:0] op, input logic [4:0] phy,
                             input logic [4:0] ra, input logic [1:0] ta,
                             input logic [15:0] data, input bit exp_wr, input string req);
    int wr0;
    bit oe_bad;
    oe_bad = 1'b0;
    wr0 = wr_pulses;
    start_frame(npre, op, phy, ra);
    send_bit(ta[1]);
    send_bit(ta[0]);
    for (int i = 15; i >= 0; i--) begin
      send_bit(data[i]);
      if (mdio_oe) oe_bad = 1'b1;
    end
    @(negedge mdc);
    m_drv = 1'b1;
    chk(reg_wr == exp_wr, req, "write strobe after last data bit", reg_wr, exp_wr);
    if (exp_wr) begin
      chk(reg_addr == ra, req, "write address", reg_addr, ra);
      chk(reg_wdata == data, req, "write data", reg_wdata, data);
    end
    @(negedge mdc);
    chk(!reg_wr, req, "write strobe one cycle", reg_wr, 0);
    chk(!oe_bad, req, "no drive during write", oe_bad, 0);
    chk(wr_pulses - wr0 == int'(exp_wr), req, "write strobe count", wr_pulses - wr0, int'(exp_wr));
  endtask

  function automatic logic [15:0] exp_read(input logic [4:0] ra);
    return IMPL_B[ra] ? model[ra] : 16'h0000;
  endfunction

  task automatic test_reset();
    chk(!mdio_oe && !reg_rd && !reg_wr, "R1", "outputs quiet in reset",
        {mdio_oe, reg_rd, reg_wr}, 0);
    repeat (3) @(negedge mdc);
    rst_n = 1'b1;
    repeat (40) @(negedge mdc);
    chk(!mdio_oe && !reg_rd && !reg_wr, "R1", "outputs quiet after reset",
        {mdio_oe, reg_rd, reg_wr}, 0);
  endtask

  task automatic test_basic_read();
    read_frame(32, 5'd0, 5'd2, 1'b1, 1'b1, exp_read(5'd2), "R4");
    read_frame(40, 5'd0, 5'd0, 1'b1, 1'b1, exp_read(5'd0), "R5");
    read_frame(32, 5'd0, 5'd31, 1'b1, 1'b1, exp_read(5'd31), "R5");
  endtask

  task automatic test_write_read();
    write_frame(32, 2'b01, 5'd0, 5'd4, 2'b10, 16'hBEEF, 1'b1, "R6");
    read_frame(32, 5'd0, 5'd4, 1'b1, 1'b1, 16'hBEEF, "R6");
    write_frame(32, 2'b01, 5'd0, 5'd27, 2'b10, 16'h8001, 1'b1, "R6");
    read_frame(32, 5'd0, 5'd27, 1'b1, 1'b1, 16'h8001, "R6");
  endtask

  task automatic test_preamble();
    read_frame(31, 5'd0, 5'd1, 1'b0, 1'b0, 16'h0, "R2");
    write_frame(31, 2'b01, 5'd0, 5'd1, 2'b10, 16'h1234, 1'b0, "R2");
    read_frame(32, 5'd0, 5'd1, 1'b1, 1'b1, exp_read(5'd1), "R2");
  endtask

  task automatic test_address();
    read_frame(32, 5'd3, 5'd1, 1'b0, 1'b0, 16'h0, "R3");
    read_frame(32, 5'd8, 5'd1, 1'b0, 1'b0, 16'h0, "R3");
    phy_strap = 2'b11;
    read_frame(32, 5'd3, 5'd3, 1'b1, 1'b1, exp_read(5'd3), "R3");
    read_frame(32, 5'd0, 5'd3, 1'b0, 1'b0, 16'h0, "R3");
    phy_strap = 2'b01;
    read_frame(32, 5'd1, 5'd3, 1'b0, 1'b0, 16'h0, "R3");
    write_frame(32, 2'b01, 5'd3, 5'd5, 2'b10, 16'h00F0, 1'b1, "R3");
    phy_strap = 2'b00;
    write_frame(32, 2'b01, 5'd3, 5'd5, 2'b10, 16'h0F00, 1'b0, "R3");
    read_frame(32, 5'd0, 5'd5, 1'b1, 1'b1, 16'h00F0, "R3");
  endtask

  task automatic test_bad_ta();
    write_frame(32, 2'b01, 5'd0, 5'd6, 2'b11, 16'hAAAA, 1'b0, "R7");
    write_frame(32, 2'b01, 5'd0, 5'd6, 2'b00, 16'h5555, 1'b0, "R7");
    read_frame(32, 5'd0, 5'd6, 1'b1, 1'b1, exp_read(5'd6), "R7");
  endtask

  task automatic test_unimpl();
    read_frame(32, 5'd0, 5'd16, 1'b1, 1'b0, 16'h0000, "R8");
    read_frame(32, 5'd0, 5'd9, 1'b1, 1'b0, 16'h0000, "R8");
    write_frame(32, 2'b01, 5'd0, 5'd16, 2'b10, 16'hFFFF, 1'b0, "R8");
  endtask

  task automatic test_no_preamble_rearm();
    read_frame(32, 5'd0, 5'd7, 1'b1, 1'b1, exp_read(5'd7), "R9");
    read_frame(0, 5'd0, 5'd7, 1'b0, 1'b0, 16'h0, "R9");
    write_frame(0, 2'b01, 5'd0, 5'd7, 2'b10, 16'h0BAD, 1'b0, "R9");
    read_frame(32, 5'd0, 5'd7, 1'b1, 1'b1, exp_read(5'd7), "R9");
  endtask

  task automatic test_bad_opcode();
    write_frame(32, 2'b00, 5'd0, 5'd2, 2'b10, 16'h1111, 1'b0, "R10");
    write_frame(32, 2'b11, 5'd0, 5'd2, 2'b10, 16'h2222, 1'b0, "R10");
    read_frame(32, 5'd0, 5'd2, 1'b1, 1'b1, exp_read(5'd2), "R10");
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 16'(i * 16'h0923 + 16'h5A01);
    test_reset();
    test_basic_read();
    test_write_read();
    test_preamble();
    test_address();
    test_bad_ta();
    test_unimpl();
    test_no_preamble_rearm();
    test_bad_opcode();
    repeat (5) @(negedge mdc);
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

endmodule